// File: doc/BRIEF.md
# Constant-Delay Time-Slot Interchanger

This block switches 8-bit channels between two time-division multiplexed streams that share one 125 µs frame. Both streams run on a common base timebase of 128 cycles per frame. Each stream can be set on its own to carry 32, 64 or 128 channels. A channel therefore occupies 4, 2 or 1 base cycles. The input byte for a channel is presented in parallel and captured once per channel slot. The output byte for each output channel is driven for its whole slot.

A connection map holds, for every output channel, the index of the input channel whose byte it carries. Several outputs may name the same source. The map is loaded through a one-cycle write strobe, and a staged copy of it is switched in only on frame boundaries. A single mode input selects between two ways of switching:

- **Fixed-latency switching** reads data from two frames back. Every output sees the same whole-frame-aligned data, whatever its position in the frame.
- **Lowest-latency switching** reads the newest copy of each source byte.

Three data pages rotate on the frame pulse to support both modes. Rates and mode are meant to be changed at a frame start.

Top module: `tsi_switch`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_data` becomes 0. Reset also sets every connection map entry to source 0, and puts the base cycle counter and the write page at 0.
- R2: A cycle in which `frame_sync` is high is the last base cycle of a frame. The following cycle is the first base cycle of channel 0 on both streams, and the write page moves to the next of three pages.
- R3: With `const_mode` = 1, the output in every cycle of output channel m in frame F equals the byte captured at input channel map[m] during frame F-2. This holds for every output that names that source.
- R4: Rate code 0 gives 32 channels of 4 base cycles, code 1 gives 64 channels of 2 base cycles, and codes 2 and 3 give 128 channels of 1 base cycle. Channel k of a stream covers base cycles k·L to k·L+L-1, where L is the channel length in base cycles. The input byte is sampled in the last of these cycles. Source indices in the map count input channels, so the input and output rates may differ.
- R5: `out_data` changes only at the first base cycle of an output channel slot and holds steady for the rest of the slot.
- R6: With `const_mode` = 0, output channel m in frame F carries the byte from input channel k = map[m] captured in frame F, if the capture cycle (k+1)·Lin−1 is earlier than the slot start m·Lout. Otherwise it carries the byte captured in frame F−1.
- R7: A map write (`cm_we` with `cm_addr` = output channel and `cm_src` = input channel) takes effect from the frame that follows the next frame pulse. If the write happens in the pulse cycle itself, it waits for one more frame boundary. Within a frame, outputs never mix old and new map contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base cycle clock, 128 cycles per frame |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | High in the last base cycle of each frame |
| const_mode | input | 1 | 1 = fixed two-frame latency, 0 = lowest latency |
| in_rate | input | 2 | Input stream rate code |
| out_rate | input | 2 | Output stream rate code |
| in_data | input | 8 | Byte of the current input channel |
| cm_we | input | 1 | Connection map write strobe |
| cm_addr | input | 7 | Output channel being mapped |
| cm_src | input | 7 | Input channel it should carry |
| out_data | output | 8 | Byte of the current output channel |

## Verification
The bench sweeps every pairing of input and output rates in fixed-latency mode and several pairings in lowest-latency mode. It predicts each output byte from frame and channel arithmetic and compares it in every base cycle.

- **Wrong page arithmetic.** A design that got it wrong would show bytes one or three frames stale.
- **Source-arrival test.** The lowest-latency cases check slots where the source arrives just before, exactly at, or after the output slot. An off-by-one in that test would hand out the previous frame's byte, or a byte not yet captured.
- **Map updates.** Map rewrites in the middle of checked frames, including one issued in the pulse cycle, catch a design that applies writes at once or at the wrong boundary; such a design would mix two mappings in one frame.
- **Slot length and scaling.** Mismatched rates catch errors in channel length and source scaling.

// File: rtl/tsi_pkg.sv
// Shared types and helpers for the time-slot interchanger.
// Assumes three rate steps: 4, 2 and 1 base cycles per channel.
package tsi_pkg;

    localparam int RATE_STEPS = 3;
    localparam int PAGE_COUNT = 3;
    localparam int SHIFT_MAX  = RATE_STEPS - 1;

    typedef logic [1:0] page_t;
    typedef logic [1:0] rate_t;

    // log2 of the channel length in base cycles for a rate code
    function automatic logic [1:0] rate_shift(input rate_t code);
        return (code >= 2'd2) ? 2'd0 : (2'd2 - code);
    endfunction

    // next page in the rotation 0 -> 1 -> 2 -> 0
    function automatic page_t page_inc(input page_t p);
        return (p == 2'd2) ? 2'd0 : p + 2'd1;
    endfunction

    // previous page in the rotation
    function automatic page_t page_dec(input page_t p);
        return (p == 2'd0) ? 2'd2 : p - 2'd1;
    endfunction

endpackage

// File: rtl/tsi_timebase.sv
// Frame timebase: counts base cycles within a frame and rotates the
// data page index. frame_sync marks the last cycle of a frame.
// Also offers the values the counters take after the coming edge.
module tsi_timebase
    import tsi_pkg::*;
#(
    parameter int CH_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_sync,
    output logic [CH_W-1:0] cyc_q,
    output logic [CH_W-1:0] cyc_nxt,
    output page_t           wpage_q,
    output page_t           wpage_nxt
);

    // look-ahead of the counter and page after the current edge
    always_comb begin
        cyc_nxt   = frame_sync ? '0 : cyc_q + CH_W'(1);
        wpage_nxt = frame_sync ? page_inc(wpage_q) : wpage_q;
    end

    // register the cycle count and write page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            wpage_q <= '0;
        end else begin
            cyc_q   <= cyc_nxt;
            wpage_q <= wpage_nxt;
        end
    end

endmodule

// File: rtl/tsi_conn_map.sv
// Connection map with staged and live copies. Writes land in the staged
// copy; the live copy takes it over on the frame pulse. Reads made in
// the pulse cycle already see the staged copy, since they serve the
// first slot of the new frame.
module tsi_conn_map #(
    parameter int CH_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_sync,
    input  logic            we,
    input  logic [CH_W-1:0] waddr,
    input  logic [CH_W-1:0] wsrc,
    input  logic [CH_W-1:0] raddr,
    output logic [CH_W-1:0] rsrc
);

    localparam int ENTRIES = 1 << CH_W;

    logic [CH_W-1:0] staged [ENTRIES];
    logic [CH_W-1:0] live   [ENTRIES];

    // look up the mapping for the slot that starts after this edge
    always_comb rsrc = frame_sync ? staged[raddr] : live[raddr];

    // accept writes into the staged copy and promote it at frame ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                staged[i] <= '0;
                live[i]   <= '0;
            end
        end else begin
            if (frame_sync) begin
                for (int i = 0; i < ENTRIES; i++) live[i] <= staged[i];
            end
            if (we) staged[waddr] <= wsrc;
        end
    end

endmodule

// File: rtl/tsi_page_store.sv
// Rotating data pages plus the output byte register. One write and
// one read per cycle; a read of the entry being written in the same
// cycle returns the new byte. The output register loads only when
// re is high.
module tsi_page_store
    import tsi_pkg::*;
#(
    parameter int CH_W   = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  page_t             wpage,
    input  logic [CH_W-1:0]   waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  page_t             rpage,
    input  logic [CH_W-1:0]   raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int ENTRIES = 1 << CH_W;

    logic [DATA_W-1:0] mem [PAGE_COUNT][ENTRIES];
    logic              fwd;

    // same-cycle write to the addressed entry overrides the array
    always_comb fwd = we && (wpage == rpage) && (waddr == raddr);

    // store captured input bytes
    always_ff @(posedge clk) begin
        if (we) mem[wpage][waddr] <= wdata;
    end

    // load the output byte at each output slot start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= fwd ? wdata : mem[rpage][raddr];
        end
    end

endmodule

// File: rtl/tsi_switch.sv
// Time-slot interchanger top. Captures one input byte per input channel
// slot into the current write page and, one cycle before each output
// slot, fetches the mapped source byte from the page chosen by the
// switching mode. Assumes a frame of 2**CH_W base cycles and CH_W >= 2.
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int CH_W   = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              const_mode,
    input  logic [1:0]        in_rate,
    input  logic [1:0]        out_rate,
    input  logic [DATA_W-1:0] in_data,
    input  logic              cm_we,
    input  logic [CH_W-1:0]   cm_addr,
    input  logic [CH_W-1:0]   cm_src,
    output logic [DATA_W-1:0] out_data
);

    localparam int CAP_W = CH_W + SHIFT_MAX + 1;

    logic [CH_W-1:0]  cyc_q, cyc_nxt;
    page_t            wpage_q, wpage_nxt, rd_page;
    logic [1:0]       in_sh, out_sh;
    logic [CH_W-1:0]  in_mask, out_mask;
    logic             wr_en, rd_en, arrived;
    logic [CH_W-1:0]  wr_addr, rd_chan, rd_src;
    logic [CAP_W-1:0] src_last;

    tsi_timebase #(.CH_W(CH_W)) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .cyc_q      (cyc_q),
        .cyc_nxt    (cyc_nxt),
        .wpage_q    (wpage_q),
        .wpage_nxt  (wpage_nxt)
    );

    // decode slot positions of both streams from the base counter
    always_comb begin
        in_sh    = rate_shift(in_rate);
        out_sh   = rate_shift(out_rate);
        in_mask  = ~({CH_W{1'b1}} << in_sh);
        out_mask = ~({CH_W{1'b1}} << out_sh);
        wr_en    = (cyc_q & in_mask) == in_mask;
        wr_addr  = cyc_q >> in_sh;
        rd_en    = (cyc_nxt & out_mask) == '0;
        rd_chan  = cyc_nxt >> out_sh;
    end

    tsi_conn_map #(.CH_W(CH_W)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .we         (cm_we),
        .waddr      (cm_addr),
        .wsrc       (cm_src),
        .raddr      (rd_chan),
        .rsrc       (rd_src)
    );

    // choose the page to read: two frames back, or newest copy of source
    always_comb begin
        src_last = ((CAP_W'(rd_src) + CAP_W'(1)) << in_sh) - CAP_W'(1);
        arrived  = src_last <= CAP_W'(cyc_q);
        if (const_mode)
            rd_page = page_inc(wpage_nxt);
        else
            rd_page = arrived ? wpage_q : page_dec(wpage_q);
    end

    tsi_page_store #(.CH_W(CH_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .wpage (wpage_q),
        .waddr (wr_addr),
        .wdata (in_data),
        .re    (rd_en),
        .rpage (rd_page),
        .raddr (rd_src),
        .rdata (out_data)
    );

endmodule

// File: rtl/tsi_switch_chk.sv
// Property checker for tsi_switch, attached through bind. Watches the
// ports and the timebase, page and output-load signals.
module tsi_switch_chk
    import tsi_pkg::*;
#(
    parameter int CH_W   = 7,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_sync,
    input logic              const_mode,
    input logic [DATA_W-1:0] out_data,
    input logic [CH_W-1:0]   cyc_q,
    input page_t             wpage_q,
    input page_t             rd_page,
    input logic              rd_en
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> out_data == '0); // R1

    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> cyc_q == '0); // R2

    AST_PAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> wpage_q == page_inc($past(wpage_q))); // R2

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(wpage_q)); // R2

    AST_CONST_APART: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && const_mode) |-> rd_page != wpage_q); // R3

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(out_data)); // R5

endmodule

bind tsi_switch tsi_switch_chk #(.CH_W(CH_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .const_mode (const_mode),
    .out_data   (out_data),
    .cyc_q      (cyc_q),
    .wpage_q    (wpage_q),
    .rd_page    (rd_page),
    .rd_en      (rd_en)
);

// File: tb/tsi_switch_test.sv
`timescale 1ns/1ps
// Sweeps rate pairings in both modes; expected bytes come from
// frame/channel arithmetic and a model of the staged map.
module tsi_switch_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_sync;
    logic       const_mode;
    logic [1:0] in_rate, out_rate;
    logic [7:0] in_data;
    logic       cm_we;
    logic [6:0] cm_addr, cm_src;
    logic [7:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int bc = 0;
    int fr = 0;
    int cfg_fr = 0;
    bit cfg_const = 1'b1;
    int irate = 2;
    int orate = 2;
    bit finished = 1'b0;
    int staged_b [128];
    int live_b   [128];

    always #2 clk = ~clk;

    tsi_switch uut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .const_mode(const_mode), .in_rate(in_rate), .out_rate(out_rate),
        .in_data(in_data), .cm_we(cm_we), .cm_addr(cm_addr),
        .cm_src(cm_src), .out_data(out_data)
    );

    function automatic int sh(input int r);
        return (r >= 2) ? 0 : 2 - r;
    endfunction

    function automatic logic [7:0] pat(input int f, input int k);
        return 8'((f * 29 + k * 7 + 3) & 255);
    endfunction

    // compare the output of the current base cycle with the model
    task automatic check_cycle();
        int ish, osh, m, start, src, cap, inch;
        logic [7:0] exp;
        string tag;
        if (cfg_const ? (fr < cfg_fr + 2) : (fr < cfg_fr + 1)) return;
        ish = sh(irate); osh = sh(orate);
        inch = 128 >> ish;
        m = bc >> osh; start = m << osh;
        src = live_b[m];
        if (src >= inch) return;
        if (cfg_const) begin
            exp = pat(fr - 2, src);                       // R3
        end else begin
            cap = ((src + 1) << ish) - 1;                 // R6
            exp = (cap < start) ? pat(fr, src) : pat(fr - 1, src);
        end
        if (live_b[m] != staged_b[m]) tag = "R7";
        else if (bc != start)         tag = "R5";
        else if (bc == 0)             tag = "R2";
        else if (irate != orate)      tag = "R4";
        else                          tag = cfg_const ? "R3" : "R6";
        n_chk++;
        if (out_data !== exp) begin
            n_bad++;
            $display("FAIL %s frame %0d cycle %0d out ch %0d: actual=%02h expected=%02h",
                     tag, fr, bc, m, out_data, exp);
        end
    endtask

    // one base cycle: check, drive, advance the model
    task automatic step(input bit we, input int a, input int s);
        @(negedge clk);
        check_cycle();
        in_data    = pat(fr, bc >> sh(irate));
        frame_sync = (bc == 127);
        cm_we      = we;
        cm_addr    = 7'(a);
        cm_src     = 7'(s);
        @(posedge clk);
        if (bc == 127) live_b = staged_b;
        if (we) staged_b[a] = s;
        if (bc == 127) begin bc = 0; fr++; end
        else bc++;
    endtask

    // five frames with one rate/mode setting and two map loads
    task automatic run_config(input bit c, input int ir, input int orr, input int idx);
        int inch;
        cfg_fr = fr; cfg_const = c; irate = ir; orate = orr;
        const_mode = c; in_rate = 2'(ir); out_rate = 2'(orr);
        inch = 128 >> sh(ir);
        for (int k = 0; k < 128; k++) step(1'b1, k, (k * 3 + idx) % inch);
        for (int k = 0; k < 128; k++) step(1'b0, 0, 0);
        // R7: rewrite mid-frame, last write lands in the pulse cycle
        for (int k = 0; k < 128; k++) step(1'b1, k, inch - 1 - (k % inch));
        for (int k = 0; k < 256; k++) step(1'b0, 0, 0);
    endtask

    initial begin
        rst_n = 1'b0; frame_sync = 1'b0; const_mode = 1'b1;
        in_rate = 2'd2; out_rate = 2'd2; in_data = '0;
        cm_we = 1'b0; cm_addr = '0; cm_src = '0;
        for (int i = 0; i < 128; i++) begin staged_b[i] = 0; live_b[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;                                          // R1
        if (out_data !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 reset: actual=%02h expected=00", out_data);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;
        // R3/R4: every rate pairing with fixed latency
        for (int ir = 0; ir < 3; ir++)
            for (int orr = 0; orr < 3; orr++)
                run_config(1'b1, ir, orr, ir * 3 + orr);
        // R6: lowest latency, equal and mixed rates
        run_config(1'b0, 2, 2, 1);
        run_config(1'b0, 0, 2, 2);
        run_config(1'b0, 2, 0, 3);
        run_config(1'b0, 1, 1, 4);
        run_config(1'b0, 3, 1, 5);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule